// File: doc/BRIEF.md
# Leading-Edge Triangle PWM Modulator

This block builds a digital triangular ramp from an up/down counter and compares it against an unsigned error magnitude to produce one PWM pulse per ramp period. The comparison is active only while the ramp is falling. The pulse turns on once the falling ramp has dropped below the magnitude, and it ends at the valley, which is also the cycle boundary. As a result the duty cycle can never exceed one half, and a synchronous rectifier can be timed from the cycle-start strobe that follows the pulse directly.

The half-period length is an input and applies live. A current-limit flag acts one cycle at a time: if it is seen during a falling slope, any pulse is blocked for the rest of that slope. A range-good output shows when the demanded duty lies strictly between zero and one half.

Top module: `tri_pwm_mod`

## Requirements
- R1: While reset is high, and on the first clock after it, `pwm_out` is 0, `slope_up` is 1 and `cycle_start` is 1, because the ramp sits at value 0 and is rising.
- R2: With effective half length H, where H = `half_in` and a value of 0 counts as 1, the ramp takes values 0,1,…,H-1 over H clocks with `slope_up`=1. It then takes H-1,…,0 over H clocks with `slope_up`=0. One period is therefore 2H clocks.
- R3: `pwm_out` is never 1 while `slope_up` is 1.
- R4: On a falling clock, `pwm_out` is 1 exactly when the ramp value is below `mag_in`. This gives one contiguous pulse of min(`mag_in`,H) clocks that ends on the last falling clock (ramp value 0).
- R5: With `mag_in`=0 there is no pulse. With `mag_in` ≥ H the pulse covers the whole falling half, which is 50% duty.
- R6: `cycle_start` is 1 for exactly one clock per period: the first rising clock, where the ramp value is 0.
- R7: `range_good` is 1 exactly when 0 < `mag_in` < H.
- R8: If `lim_in` is 1 on any falling clock, `pwm_out` is 0 on that clock and on every remaining clock of that falling slope. The next period is unaffected.
- R9: If `lim_in` is 1 during the rising slope, the following falling slope is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mag_in | input | CW | Unsigned error magnitude, on the same scale as the ramp |
| half_in | input | CW | Half-period length in clocks (0 acts as 1) |
| lim_in | input | 1 | Current-limit flag, acts one cycle at a time |
| pwm_out | output | 1 | PWM pulse |
| cycle_start | output | 1 | One-clock strobe at the valley that starts a period |
| slope_up | output | 1 | 1 while the ramp is rising |
| range_good | output | 1 | Demanded duty lies strictly between 0 and one half |

## Verification
The bench targets the following corner cases, and each one exposes a specific class of bug.

- **Magnitude at the extremes (0, exactly H, far above H).** An off-by-one in the comparison would let a pulse through at zero, or lose the last clock at full duty.
- **Degenerate half lengths of 1 and 0.** A counter that underflows its turning point would run away here.
- **Current limit asserted before the pulse starts and again in the middle of the pulse.** A design that only gates the present clock would let the pulse resume after the limit drops.
- **Limit asserted during the rising slope.** A design that remembers this limit would wrongly suppress the following pulse.

// File: rtl/tri_pwm_mod.sv
module tri_pwm_mod #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] mag_in,
  input  logic [CW-1:0] half_in,
  input  logic          lim_in,
  output logic          pwm_out,
  output logic          cycle_start,
  output logic          slope_up,
  output logic          range_good
);

  logic [CW-1:0] ramp;
  logic [CW-1:0] peak;
  logic          up;
  logic          blk;

  assign peak = (half_in == '0) ? '0 : half_in - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp <= '0;
      up   <= 1'b1;
      blk  <= 1'b0;
    end else if (up) begin
      blk <= 1'b0;
      if (ramp >= peak) up <= 1'b0;
      else ramp <= ramp + 1'b1;
    end else begin
      blk <= blk | lim_in;
      if (ramp == '0) up <= 1'b1;
      else ramp <= ramp - 1'b1;
    end
  end

  assign pwm_out     = !up && (ramp < mag_in) && !blk && !lim_in;
  assign cycle_start = up && (ramp == '0);
  assign slope_up    = up;
  assign range_good  = (mag_in != '0) && (mag_in <= peak);

endmodule

module tri_pwm_mod_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] mag_in,
  input logic          lim_in,
  input logic          pwm_out,
  input logic          cycle_start,
  input logic          slope_up
);

  AST_NO_PWM_RISING: assert property (@(posedge clk) disable iff (rst)
    slope_up |-> !pwm_out); // R3

  AST_LIM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!slope_up && lim_in) |=> (!pwm_out || slope_up)); // R8

  AST_PULSE_ENDS_AT_VALLEY: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwm_out) && $stable(mag_in)) |-> (slope_up || lim_in)); // R4

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> slope_up); // R6

  AST_LIM_NOW: assert property (@(posedge clk) disable iff (rst)
    lim_in |-> !pwm_out); // R8

endmodule

bind tri_pwm_mod tri_pwm_mod_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_tri_pwm_mod.sv
`timescale 1ns/1ps
module tb_tri_pwm_mod;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] mag_in = '0;
  logic [CW-1:0] half_in = 10'd8;
  logic lim_in = 1'b0;
  logic pwm_out, cycle_start, slope_up, range_good;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tri_pwm_mod #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .mag_in(mag_in), .half_in(half_in), .lim_in(lim_in),
    .pwm_out(pwm_out), .cycle_start(cycle_start), .slope_up(slope_up),
    .range_good(range_good)
  );

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tg, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      chk(pwm_out == e[3], e[1] ? "R3 pwm" : {tg, " pwm"}, pwm_out, e[3]);
      chk(cycle_start == e[2], "R6 cycle_start", cycle_start, e[2]);
      chk(slope_up == e[1], "R2 slope_up", slope_up, e[1]);
      chk(range_good == e[0], "R7 range_good", range_good, e[0]);
    end
  end

  task automatic run_case(input int mag, input int half, input int ncyc,
                          input int lc, input int lk, input string tg);
    int h;
    bit blocked;
    h = (half == 0) ? 1 : half;
    blocked = 0;
    @(posedge clk); #1;
    rst = 1'b1; mag_in = mag[CW-1:0]; half_in = half[CW-1:0]; lim_in = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      for (int k = 0; k < 2*h; k++) begin
        bit rising, lim, p, cs, rg;
        int r;
        if (k != 0 || cyc != 0) begin @(posedge clk); #1; end
        lim = (cyc == lc) && (k == lk);
        lim_in = lim;
        rising = (k < h);
        r = rising ? k : 2*h - 1 - k;
        if (k == h) blocked = 0;
        if (!rising && lim) blocked = 1;
        p  = !rising && (r < mag) && !blocked;
        cs = (k == 0);
        rg = (mag != 0) && (mag < h);
        exp_q.push_back({p, cs, rising, rg});
        tag_q.push_back(tg);
      end
    end
    @(posedge clk); #1;
    lim_in = 1'b0;
    wait (exp_q.size() == 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 pwm", pwm_out, 0);
    chk(slope_up == 1'b1, "R1 slope_up", slope_up, 1);
    chk(cycle_start == 1'b1, "R1 cycle_start", cycle_start, 1);

    run_case(3,    8,   2, -1, -1, "R4");
    run_case(0,    8,   2, -1, -1, "R5");
    run_case(8,    8,   2, -1, -1, "R5");
    run_case(1000, 8,   1, -1, -1, "R5");
    run_case(7,    8,   1, -1, -1, "R7");
    run_case(6,    8,   2,  0, 10, "R8");
    run_case(6,    8,   2,  0, 13, "R8");
    run_case(6,    8,   2,  0,  3, "R9");
    run_case(1,    1,   3, -1, -1, "R2");
    run_case(1,    0,   3, -1, -1, "R2");
    run_case(40,   100, 1, -1, -1, "R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule